// File: doc/BRIEF.md
# Posted Interrupt Controller with Masking

This block gathers eight hardware event lines into sticky pending bits. Each source has its own enable in a mask register, and a global enable input gates the whole controller. Whenever at least one pending source is also unmasked and the global enable is high, the controller raises a request toward the CPU core. It also drives a vector byte that points into the interrupt table entry of the winning source. When the core takes the interrupt it pulses an acknowledge, and the controller retires the pending bit of the source it was presenting at that moment.

Software reaches the block through a small register window. The pending register acts as a status view when read. A write to it clears every bit written as zero. A bit written as one posts that source, but only while the software-post enable in the control register is set. Priority is fixed: the lowest source index wins. The vector is four times one more than that index, so source 0 (power-on / low-voltage) maps to 0x04.

Top module: `irq_post_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the pending, mask and control registers. After reset `irq_req` is 0, `irq_vec` is 0x00, and every register address reads 0x00.
- R2: A one-cycle pulse on `src_evt[i]` sets pending bit i at the next clock edge, whatever the mask and global enable. The bit then stays set until it is cleared or retired.
- R3: Address 0 reads the pending bits. A write to address 0 clears, at the next edge, every pending bit whose write-data bit is 0.
- R4: A write to address 0 sets every pending bit whose write-data bit is 1, but only while control-register bit 7 (the software-post enable) is 1. With that bit at 0, a written 1 leaves the pending bit as it was.
- R5: `irq_req` is 1 exactly when `glb_en` is 1 and some bit is both pending and unmasked, with no register delay. A request therefore appears when an event arrives on an unmasked source, when the mask is written to enable an already pending source, or when `glb_en` rises while an unmasked source is pending.
- R6: Among the pending and unmasked sources, the lowest index i wins, and `irq_vec` = 4 × (i + 1). The sources map as follows: bit 0 power-on / low-voltage (0x04), bit 1 external 0 (0x08), bit 2 SPI transmit (0x0C), bit 3 SPI receive (0x10), bit 4 GPIO port 0 (0x14), bit 5 external 1 (0x18), bit 6 sleep timer (0x1C), bit 7 GPIO port 1 (0x20). `irq_vec` is 0x00 when no source is pending and unmasked, and it is not gated by `glb_en`.
- R7: If `irq_ack` is 1 in a cycle where `irq_req` is 1, the pending bit of the source named by `irq_vec` in that cycle is cleared at the next edge, and no other bit changes. If `irq_ack` is 1 while `irq_req` is 0, it has no effect.
- R8: If an event pulse and a clear arrive for the same bit in the same cycle, the set wins. The clear may come from a register write or from an acknowledge.
- R9: Address 1 holds the mask (1 = enabled) and reads back what was written. Address 2 stores only bit 7, and its other bits read 0. Address 3 reads 0x00. `reg_rdata` follows `reg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 8 | One-cycle event pulses, one per source |
| glb_en | input | 1 | Global interrupt enable from the core |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 pending, 1 mask, 2 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector byte of the winning source |
| irq_ack | input | 1 | Acknowledge from the core; retires the presented source |

## Verification
The properties assume that `src_evt` holds no stray values during reset. They also assume that the core asserts `irq_ack` only at cycle granularity, never sampling `irq_vec` mid-cycle. Where a property describes the pure effect of a write or an acknowledge, its precondition excludes same-cycle events, so that the set-wins rule of R8 does not mask the behaviour under test. The stimulus changes inputs only between clock edges, a fixed delay after the falling edge. It covers the conflicting same-cycle cases separately, with directed steps and with the expected pending values worked out by hand.

// File: rtl/irq_post_pkg.sv
`timescale 1ns/1ps
package irq_post_pkg;

    localparam int unsigned SRC_N    = 8;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned SWEN_BIT = 7;
    localparam int unsigned VEC_STEP = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_PEND = 2'd0,
        RA_MASK = 2'd1,
        RA_CTRL = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    // Per-bit update terms that feed the pending bank.
    typedef struct packed {
        logic [SRC_N-1:0] keep;   // 0 = drop the bit this cycle
        logic [SRC_N-1:0] set;    // 1 = post the bit this cycle
    } pend_upd_t;

    // Table slot of a source: one step past its index.
    function automatic logic [DATA_W-1:0] vec_of(input int unsigned idx);
        return DATA_W'((idx + 1) * VEC_STEP);
    endfunction

endpackage

// File: rtl/irq_regif.sv
`timescale 1ns/1ps
module irq_regif
    import irq_post_pkg::*;
#(
    parameter int unsigned N = SRC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [N-1:0]      pend_q,
    output logic [N-1:0]      mask_q,
    output logic              swen_q,
    output pend_upd_t         wr_upd,
    output logic [DATA_W-1:0] reg_rdata
);

    reg_addr_e addr_e;
    logic      wr_pend;
    logic      wr_mask;
    logic      wr_ctrl;
    logic [N-1:0] wdata_n;

    assign addr_e  = reg_addr_e'(reg_addr);
    assign wr_pend = reg_wr && (addr_e == RA_PEND);
    assign wr_mask = reg_wr && (addr_e == RA_MASK);
    assign wr_ctrl = reg_wr && (addr_e == RA_CTRL);
    assign wdata_n = N'(reg_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            swen_q <= 1'b0;
        end else begin
            if (wr_mask) mask_q <= wdata_n;
            if (wr_ctrl) swen_q <= reg_wdata[SWEN_BIT];
        end
    end

    // Write-zero drops a bit, write-one posts it only with the enable set.
    always_comb begin
        wr_upd.keep = '1;
        wr_upd.set  = '0;
        if (wr_pend) begin
            wr_upd.keep = wdata_n;
            if (swen_q) wr_upd.set = wdata_n;
        end
    end

    always_comb begin
        unique case (addr_e)
            RA_PEND: reg_rdata = DATA_W'(pend_q);
            RA_MASK: reg_rdata = DATA_W'(mask_q);
            RA_CTRL: reg_rdata = DATA_W'({swen_q, {SWEN_BIT{1'b0}}});
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_pend_bank.sv
`timescale 1ns/1ps
module irq_pend_bank
    import irq_post_pkg::*;
#(
    parameter int unsigned N = SRC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_evt,
    input  logic [N-1:0] ack_clr,
    input  pend_upd_t    wr_upd,
    output logic [N-1:0] pend_q
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic hold;
        logic post;
        assign hold = pend_q[g] && !ack_clr[g] && wr_upd.keep[g];
        assign post = src_evt[g] || wr_upd.set[g];
        always_ff @(posedge clk) begin
            if (rst) pend_q[g] <= 1'b0;
            else     pend_q[g] <= hold || post;
        end
    end

endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc
    import irq_post_pkg::*;
#(
    parameter int unsigned N = SRC_N,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]      act,
    output logic              hit,
    output logic [N-1:0]      grant_oh,
    output logic [DATA_W-1:0] vec
);

    logic [IDX_W-1:0] idx_sel;

    // Scan from the top so the lowest active index is the last to land.
    always_comb begin
        hit      = 1'b0;
        grant_oh = '0;
        idx_sel  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (act[i]) begin
                hit      = 1'b1;
                grant_oh = N'(1) << i;
                idx_sel  = IDX_W'(i);
            end
        end
    end

    assign vec = hit ? vec_of(int'(idx_sel)) : '0;

endmodule

// File: rtl/irq_post_ctrl.sv
`timescale 1ns/1ps
module irq_post_ctrl
    import irq_post_pkg::*;
#(
    parameter int unsigned N = SRC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      src_evt,
    input  logic              glb_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req,
    output logic [DATA_W-1:0] irq_vec,
    input  logic              irq_ack
);

    logic [N-1:0] pend_q;
    logic [N-1:0] mask_q;
    logic         swen_q;
    pend_upd_t    wr_upd;
    logic [N-1:0] act;
    logic [N-1:0] grant_oh;
    logic         hit;
    logic [N-1:0] ack_clr;

    irq_regif #(.N(N)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pend_q    (pend_q),
        .mask_q    (mask_q),
        .swen_q    (swen_q),
        .wr_upd    (wr_upd),
        .reg_rdata (reg_rdata)
    );

    irq_pend_bank #(.N(N)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .src_evt (src_evt),
        .ack_clr (ack_clr),
        .wr_upd  (wr_upd),
        .pend_q  (pend_q)
    );

    assign act = pend_q & mask_q;

    irq_prio_enc #(.N(N)) u_prio (
        .act      (act),
        .hit      (hit),
        .grant_oh (grant_oh),
        .vec      (irq_vec)
    );

    assign irq_req = glb_en && hit;
    assign ack_clr = (irq_ack && irq_req) ? grant_oh : '0;

endmodule

// File: rtl/irq_post_chk.sv
`timescale 1ns/1ps
module irq_post_chk
    import irq_post_pkg::*;
#(
    parameter int unsigned N = SRC_N
) (
    input logic              clk,
    input logic              rst,
    input logic [N-1:0]      src_evt,
    input logic              glb_en,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq_ack,
    input logic              irq_req,
    input logic [DATA_W-1:0] irq_vec,
    input logic [N-1:0]      pend_q,
    input logic [N-1:0]      mask_q,
    input logic              swen_q
);

    logic [N-1:0] live;
    logic [N-1:0] low_bit;
    logic         quiet_wr;

    assign live     = pend_q & mask_q;
    assign low_bit  = live & (~live + N'(1));
    assign quiet_wr = reg_wr && (reg_addr == ADDR_W'(RA_PEND)) && (src_evt == '0);

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !irq_req); // R1

    AST_EVT_STICKS: assert property (@(posedge clk) disable iff (rst)
        (src_evt != '0) |=> ((pend_q & $past(src_evt)) == $past(src_evt))); // R2

    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
        quiet_wr |=> ((pend_q & ~$past(N'(reg_wdata))) == '0)); // R3

    AST_POST_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (quiet_wr && !swen_q && !irq_ack) |=> (pend_q == $past(pend_q & N'(reg_wdata)))); // R4

    AST_REQ_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        !glb_en |-> !irq_req); // R5

    AST_VEC_SLOT: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec != '0 && irq_vec[1:0] == 2'b00)); // R6

    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req && src_evt == '0 && !reg_wr)
        |=> (pend_q == ($past(pend_q) & ~$past(low_bit)))); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (src_evt != '0 && (irq_ack || reg_wr))
        |=> ((pend_q & $past(src_evt)) == $past(src_evt))); // R8

endmodule

bind irq_post_ctrl irq_post_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_evt   (src_evt),
    .glb_en    (glb_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .swen_q    (swen_q)
);

// File: tb/test_irq_post_ctrl.sv
`timescale 1ns/1ps
module test_irq_post_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] src_evt = '0;
    logic       glb_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_req;
    logic [7:0] irq_vec;
    logic       irq_ack = 1'b0;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic       req;
        logic [7:0] vec;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    irq_post_ctrl i_irq_post_ctrl (
        .clk       (clk),
        .rst       (rst),
        .src_evt   (src_evt),
        .glb_en    (glb_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec),
        .irq_ack   (irq_ack)
    );

    // Monitor: compares observed outputs with queued expectations.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_run++;
                if (reg_rdata !== e.rd || irq_req !== e.req || irq_vec !== e.vec) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h req=%b vec=%h expected rdata=%h req=%b vec=%h",
                             e.tag, reg_rdata, irq_req, irq_vec, e.rd, e.req, e.vec);
                end
            end
        end
    end

    task automatic step(input logic [7:0] evt, input logic wr, input logic [1:0] a,
                        input logic [7:0] d, input logic ack);
        @(negedge clk); #1;
        src_evt = evt; reg_wr = wr; reg_addr = a; reg_wdata = d; irq_ack = ack;
        @(posedge clk); #1;
        src_evt = '0; reg_wr = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        step(8'h00, 1'b1, a, d, 1'b0);
    endtask

    task automatic set_glb(input logic v);
        @(negedge clk); #1;
        glb_en = v;
    endtask

    // Driver side of the scoreboard: queue the expectation, then let it be sampled.
    task automatic expect_obs(input string tag, input logic [1:0] a, input logic [7:0] rd,
                              input logic req, input logic [7:0] vec);
        exp_t e;
        reg_addr = a;
        e.tag = tag; e.rd = rd; e.req = req; e.vec = vec;
        sb_q.push_back(e);
        @(negedge clk); #1;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        expect_obs("R1 pending after reset", 2'd0, 8'h00, 1'b0, 8'h00);
        expect_obs("R1 mask after reset",    2'd1, 8'h00, 1'b0, 8'h00);
        expect_obs("R1 control after reset", 2'd2, 8'h00, 1'b0, 8'h00);

        set_glb(1'b1);
        step(8'h24, 1'b0, 2'd0, 8'h00, 1'b0);
        expect_obs("R2 events post while masked", 2'd0, 8'h24, 1'b0, 8'h00);

        wreg(2'd1, 8'h20);
        expect_obs("R5 mask write enables posted source", 2'd1, 8'h20, 1'b1, 8'h18);

        wreg(2'd1, 8'hFF);
        expect_obs("R6 lowest index wins", 2'd0, 8'h24, 1'b1, 8'h0C);

        set_glb(1'b0);
        expect_obs("R5 global enable low blocks request", 2'd0, 8'h24, 1'b0, 8'h0C);

        step(8'h00, 1'b0, 2'd0, 8'h00, 1'b1);
        expect_obs("R7 ack without request ignored", 2'd0, 8'h24, 1'b0, 8'h0C);

        set_glb(1'b1);
        expect_obs("R5 global enable rise raises request", 2'd0, 8'h24, 1'b1, 8'h0C);

        step(8'h00, 1'b0, 2'd0, 8'h00, 1'b1);
        expect_obs("R7 ack retires presented source", 2'd0, 8'h20, 1'b1, 8'h18);

        wreg(2'd0, 8'hFF);
        expect_obs("R4 write one without enable ignored", 2'd0, 8'h20, 1'b1, 8'h18);

        wreg(2'd0, 8'hDF);
        expect_obs("R3 write zero clears", 2'd0, 8'h00, 1'b0, 8'h00);

        wreg(2'd2, 8'hFF);
        expect_obs("R9 control keeps only bit 7", 2'd2, 8'h80, 1'b0, 8'h00);

        wreg(2'd0, 8'h81);
        expect_obs("R4 software post with enable", 2'd0, 8'h81, 1'b1, 8'h04);

        step(8'h02, 1'b1, 2'd0, 8'h00, 1'b0);
        expect_obs("R8 event beats write clear", 2'd0, 8'h02, 1'b1, 8'h08);

        step(8'h02, 1'b0, 2'd0, 8'h00, 1'b1);
        expect_obs("R8 event beats ack clear", 2'd0, 8'h02, 1'b1, 8'h08);

        wreg(2'd1, 8'h00);
        expect_obs("R5 all masked gives no request", 2'd0, 8'h02, 1'b0, 8'h00);

        step(8'h80, 1'b0, 2'd0, 8'h00, 1'b0);
        wreg(2'd1, 8'h80);
        expect_obs("R6 top source vector", 2'd0, 8'h82, 1'b1, 8'h20);

        expect_obs("R9 unused address reads zero", 2'd3, 8'h00, 1'b1, 8'h20);

        step(8'h00, 1'b0, 2'd0, 8'h00, 1'b1);
        expect_obs("R7 ack leaves masked bit", 2'd0, 8'h02, 1'b0, 8'h00);

        wreg(2'd2, 8'h7F);
        wreg(2'd0, 8'hFF);
        expect_obs("R4 enable cleared blocks post", 2'd0, 8'h02, 1'b0, 8'h00);
        expect_obs("R9 control bit 7 cleared", 2'd2, 8'h00, 1'b0, 8'h00);

        @(negedge clk); #1;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule